// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches thirteen general-purpose input pins. It raises an interrupt when any selected pin changes level, whether the change is a rise or a fall. The pins form two groups. The low group has eight pins and the high group has five. Each pin passes through a two-flop synchronizer, and its edge is found by comparing the synchronized level with the level one clock earlier. Each group has one sticky flag, which records any qualifying change on its pins.

A pin can set its group's flag only when two things are true: its own mask bit is one and its group's enable bit is one. Software reads and writes four byte-wide registers over a simple single-cycle bus: the two mask registers, the group enables and the flags. A flag clears in either of two ways. Software can write a one to it, or the CPU can pulse the acknowledge line for that group when it enters the handler. Each group's request to the CPU is the AND of its flag, its group enable and a global interrupt enable.

Top module: `pin_change_irq`

## Requirements
- R1: A level change in either direction on a pin whose mask bit and group-enable bit are both one sets that group's flag. The flag is readable on the third rising clock edge after the change is applied: two synchronizer stages, then the flag register.
- R2: Pins 0 to 7 belong to group 0 and are masked by offset 0, where bit n masks pin n. Pins 8 to 12 belong to group 1 and are masked by bits 4:0 of offset 1, where bit n masks pin 8+n. The flag for group g is bit g of offset 3.
- R3: A change on a pin whose mask bit is zero, or whose group-enable bit is zero, leaves the flag unchanged.
- R4: irq_req[g] is 1 exactly when flag g, enable bit g (offset 2, bit g) and global_ie are all 1.
- R5: A one on irq_ack[g] clears flag g at the next clock edge.
- R6: Writing offset 3 with bit g set clears flag g. Writing it with bit g zero leaves flag g unchanged.
- R7: After reset, all mask bits, enable bits and flags are 0, and irq_req is 0.
- R8: In offset 1, bits 7:6 read 0 and ignore writes. Bit 5 holds what was written to it but affects no pin.
- R9: If a trigger and a clear (by write or by acknowledge) fall on the same clock edge, the flag ends set.
- R10: Offset 2 holds the two enable bits in bits 1:0. Bits 7:2 of offsets 2 and 3 read 0. The read data shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | 13 | Monitored asynchronous pin levels |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| global_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 2 | Per-group acknowledge pulse |
| irq_req | output | 2 | Per-group interrupt request |

## Verification
A stale synchronizer or edge history shows at the ports as a flag that rises one cycle too early or too late, or as a flag that rises with no pin change at all. Because of this, every flag read is compared on the exact cycle the requirements predict. A flag that is stuck or cleared by mistake shows up on the very next cycle, both in the offset-3 read and on irq_req. The bench therefore compares both outputs after every clock edge. Wrong mask or enable bits show up on the next read of their offset, or as a missing flag three edges after a pin change.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int G0_W        = 8,
  parameter int G1_W        = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [G0_W+G1_W-1:0] pins,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 global_ie,
  input  logic [1:0]           irq_ack,
  output logic [1:0]           irq_req
);
  localparam int NPINS = G0_W + G1_W;
  localparam int M1_W  = G1_W + 1;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] prev_q;
  logic [G0_W-1:0]  mask0_q;
  logic [M1_W-1:0]  mask1_q;
  logic [1:0]       gen_q, flag_q;

  wire [NPINS-1:0] chg = sync_q[LAST] ^ prev_q;
  wire [1:0] trig = {gen_q[1] & |(chg[NPINS-1:G0_W] & mask1_q[G1_W-1:0]),
                     gen_q[0] & |(chg[G0_W-1:0] & mask0_q)};
  wire wr_m0 = bus_wr && bus_addr == 2'd0;
  wire wr_m1 = bus_wr && bus_addr == 2'd1;
  wire wr_en = bus_wr && bus_addr == 2'd2;
  wire wr_fl = bus_wr && bus_addr == 2'd3;
  wire [1:0] clr = irq_ack | (wr_fl ? bus_wdata[1:0] : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask0_q <= '0;
      mask1_q <= '0;
      gen_q   <= '0;
      flag_q  <= '0;
    end else begin
      if (wr_m0) mask0_q <= bus_wdata[G0_W-1:0];
      if (wr_m1) mask1_q <= bus_wdata[M1_W-1:0];
      if (wr_en) gen_q   <= bus_wdata[1:0];
      flag_q <= (flag_q & ~clr) | trig;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[G0_W-1:0] = mask0_q;
      2'd1: bus_rdata[M1_W-1:0] = mask1_q;
      2'd2: bus_rdata[1:0]      = gen_q;
      default: bus_rdata[1:0]   = flag_q;
    endcase
  end

  assign irq_req = flag_q & gen_q & {2{global_ie}};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_chk
      AST_TRIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        trig[g] |=> flag_q[g]); // R9
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[g] && !trig[g]) |=> !flag_q[g]); // R3
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[g] && !trig[g]) |=> !flag_q[g]); // R5
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fl && bus_wdata[g] && !trig[g]) |=> !flag_q[g]); // R6
      AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[g] && !irq_ack[g] && !(wr_fl && bus_wdata[g])) |=> flag_q[g]); // R6
      AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !global_ie |-> !irq_req[g]); // R4
    end
  endgenerate

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> bus_rdata[DW-1:M1_W] == '0); // R8
endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  logic        clk = 0, rst_n = 0;
  logic [12:0] pins = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        global_ie = 0;
  logic [1:0]  irq_ack = '0;
  logic [1:0]  irq_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .global_ie(global_ie),
    .irq_ack(irq_ack), .irq_req(irq_req));

  // expectation model built from the requirements
  logic [12:0] s1, s2, p;
  logic [7:0]  m0;
  logic [5:0]  m1;
  logic [1:0]  en, fl;

  function automatic logic [1:0] trig_of(logic [12:0] c, logic [7:0] a, logic [5:0] b, logic [1:0] e);
    return {e[1] & |(c[12:8] & b[4:0]), e[0] & |(c[7:0] & a)};
  endfunction

  function automatic logic [7:0] view(logic [1:0] a);
    case (a)
      2'd0: return m0;
      2'd1: return {2'b00, m1};
      2'd2: return {6'b0, en};
      default: return {6'b0, fl};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; p <= '0; m0 <= '0; m1 <= '0; en <= '0; fl <= '0;
    end else begin
      logic [1:0] c;
      c = irq_ack | ((bus_wr && bus_addr == 2'd3) ? bus_wdata[1:0] : 2'b00);
      fl <= (fl & ~c) | trig_of(s2 ^ p, m0, m1, en);
      s1 <= pins; s2 <= s1; p <= s2;
      if (bus_wr && bus_addr == 2'd0) m0 <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) m1 <= bus_wdata[5:0];
      if (bus_wr && bus_addr == 2'd2) en <= bus_wdata[1:0];
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    string t;
    case (bus_addr)
      2'd0: t = "R2 mask0 read";
      2'd1: t = "R8 mask1 read";
      2'd2: t = "R10 enable read";
      default: t = "R1 flag read";
    endcase
    chk(bus_rdata, view(bus_addr), t);
    chk({6'b0, irq_req}, {6'b0, fl & en & {2{global_ie}}}, "R4 irq_req");
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    compare();
    bus_wr = 0; irq_ack = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d; cyc();
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1; chk(bus_rdata, exp, tag);
  endtask

  initial begin
    process::self().srandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset values
    rd(2'd0, 8'h00, "R7 mask0 reset");
    rd(2'd1, 8'h00, "R7 mask1 reset");
    rd(2'd2, 8'h00, "R7 enable reset");
    rd(2'd3, 8'h00, "R7 flag reset");
    chk({6'b0, irq_req}, 8'h00, "R7 irq reset");

    // R8 reserved bits
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h3F, "R8 mask1 bits 7:6 read zero");
    // R8 bit 5 has no pin effect; R3 with masks clear
    wr(2'd1, 8'h20); wr(2'd2, 8'h03); global_ie = 1;
    pins = 13'h1FFF; repeat (4) cyc();
    rd(2'd3, 8'h00, "R3/R8 unmasked pins and spare bit do not trigger");

    // R1 latency on pin 9 (R2: bit 1 of offset 1), falling edge
    wr(2'd1, 8'h02);
    pins[9] = 0; cyc(); cyc();
    rd(2'd3, 8'h00, "R1 flag not yet after two edges");
    cyc();
    rd(2'd3, 8'h02, "R1 group1 flag after third edge");
    chk({6'b0, irq_req}, 8'h02, "R4 irq group1");
    global_ie = 0; #1;
    chk({6'b0, irq_req}, 8'h00, "R4 global enable gates");
    global_ie = 1;

    // R6 write zero keeps, write one clears
    wr(2'd3, 8'h01); rd(2'd3, 8'h02, "R6 write zero keeps flag");
    wr(2'd3, 8'h02); rd(2'd3, 8'h00, "R6 write one clears flag");

    // R3 group disable blocks; R2 pin 3 maps to group 0
    wr(2'd0, 8'h08); wr(2'd2, 8'h02);
    pins[3] = 0; repeat (4) cyc();
    rd(2'd3, 8'h00, "R3 disabled group does not flag");
    wr(2'd2, 8'h03);
    pins[3] = 1; repeat (3) cyc();
    rd(2'd3, 8'h01, "R2 pin3 sets group0 flag");

    // R5 acknowledge clears
    irq_ack = 2'b01; cyc();
    rd(2'd3, 8'h00, "R5 ack clears group0 flag");

    // R9 trigger and clear on the same edge
    pins[3] = 0; cyc(); cyc();
    irq_ack = 2'b01; bus_addr = 2'd3; bus_wr = 1; bus_wdata = 8'h01; cyc();
    rd(2'd3, 8'h01, "R9 trigger wins over clear");
    wr(2'd3, 8'h03);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) pins[$urandom_range(0, 12)] ^= 1'b1;
      bus_addr = 2'($urandom_range(0, 3));
      bus_wr = ($urandom_range(0, 4) == 0);
      bus_wdata = 8'($urandom);
      irq_ack = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if ($urandom_range(0, 31) == 0) global_ie = ~global_ie;
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule